// File: doc/BRIEF.md
# Block RAM FIFO Controller with Flags

This block turns a single 1024-word by 36-bit dual-port memory into a synchronous first-in first-out queue. A producer presents a word and pulses the write request; a consumer pulses the read request and receives the oldest stored word a fixed number of cycles later, qualified by a valid strobe. Both sides share one clock.

The word width is fixed at build time to 9, 18 or 36 stored bits, which gives 4096, 2048 or 1024 entries; narrower modes pack several lanes into one memory word and the pointer width follows the depth. One stored bit in every nine is a parity bit generated on the way in, so the payload is 8, 16 or 32 bits and the parity bits are delivered next to the payload on the way out. An optional output register adds one pipeline stage to the read path.

The controller is a three-state machine. The states are IDLE-EMPTY (`ST_EMPTY`), PARTIAL (`ST_MID`) and FULL (`ST_FULL`). Transitions: `ST_EMPTY`→`ST_MID` on an accepted write; `ST_MID`→`ST_FULL` on a lone accepted write when one slot is left; `ST_MID`→`ST_EMPTY` on a lone accepted read when one word is left; `ST_FULL`→`ST_MID` on an accepted read; every other case holds the state. Occupancy is compared with two programmable thresholds to give the almost flags, and misuse sets two sticky error flags.

Top module: `bram_fifo`

## Requirements
- R1: With DW=9 the queue holds 4096 entries, with DW=18 it holds 2048, with DW=36 it holds 1024; `full` rises after exactly that many net accepted writes.
- R2: Words leave in the order they were accepted; the payload is PAY_W = DW/9*8 bits, returned unchanged on `rd_data`.
- R3: After reset `empty`=1, `full`=0, `overrun`=0, `underrun`=0, `rd_valid`=0; `empty` is 1 exactly when occupancy is zero, and `full` and `empty` are never both 1.
- R4: For an accepted read, `rd_valid` and the word appear one cycle after the request edge when OUT_REG=0 and two cycles after when OUT_REG=1.
- R5: A write request while `full` is dropped and sets `overrun`, which stays 1 until cleared; if set and clear fall in the same cycle, the set wins.
- R6: A read request while `empty` is dropped, produces no `rd_valid` and sets `underrun`, which stays 1 until cleared; set wins over a same-cycle clear.
- R7: An accepted read and an accepted write in the same cycle leave the occupancy unchanged; a write that meets `full` in the same cycle as a read is still dropped.
- R8: `almost_full` is 1 when occupancy >= `af_thr` and `almost_empty` is 1 when occupancy <= `ae_thr`, both valid the cycle after the edge that changed occupancy.
- R9: `rd_par[i]` is the XOR of payload bits [8i+7:8i] of the same word.
- R10: A cycle with `err_clr`=1 and no new error clears `overrun` and `underrun` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request |
| wr_data | input | PAY_W | Payload to store |
| rd_en | input | 1 | Read request |
| err_clr | input | 1 | Clears the sticky error flags |
| af_thr | input | CNT_W | Almost-full threshold (occupancy) |
| ae_thr | input | CNT_W | Almost-empty threshold (occupancy) |
| rd_data | output | PAY_W | Payload of the word read |
| rd_par | output | NPAR | Parity bits of the word read |
| rd_valid | output | 1 | `rd_data`/`rd_par` hold a read result |
| full | output | 1 | No free entry |
| empty | output | 1 | No stored entry |
| almost_full | output | 1 | Occupancy at or above `af_thr` |
| almost_empty | output | 1 | Occupancy at or below `ae_thr` |
| overrun | output | 1 | Sticky: write attempted while full |
| underrun | output | 1 | Sticky: read attempted while empty |

## Verification
Two pairs of functions can meet in one cycle: a read and a write together, and an error flag being set while software clears it. The first is provoked mid-fill, where the almost-full flag must keep its value and a following lone read must drop it, and again at full, where the read must be taken while the write is refused and `overrun` rises. The second is provoked by a write against a full queue with `err_clr` held, where `overrun` must stay 1, followed by a clear-only cycle that must drop it. A narrow instance with the output register and a wide instance without it run the same stimulus against their own reference queues, so lane packing, latency and depth are judged side by side.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_MID   = 2'd1,
        ST_FULL  = 2'd2
    } fill_state_t;

    localparam int MEM_WORDS  = 1024;
    localparam int MEM_BITS   = 36;
    localparam int MEM_ADDR_W = 10;

endpackage

// File: rtl/bfifo_mem.sv
module bfifo_mem #(
    parameter int LANES  = 1,
    parameter int LANE_W = 36,
    parameter int WORDS  = 1024,
    parameter int ADDR_W = 10
) (
    input  logic                      clk,
    input  logic                      we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANES-1:0]          wlane,
    input  logic [LANE_W-1:0]         wdata,
    input  logic                      re,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANES*LANE_W-1:0]   rword
);
    logic [LANES*LANE_W-1:0] store [WORDS];

    // write port: only the selected lane of the addressed word changes
    always_ff @(posedge clk) begin
        if (we) begin
            for (int l = 0; l < LANES; l++) begin
                if (wlane[l]) begin
                    store[waddr][l*LANE_W +: LANE_W] <= wdata;
                end
            end
        end
    end

    // read port: address captured at the edge, word available after it
    always_ff @(posedge clk) begin
        if (re) begin
            rword <= store[raddr];
        end
    end
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl
    import bfifo_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int PTR_W = 10,
    parameter int CNT_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic [CNT_W-1:0]  af_thr,
    input  logic [CNT_W-1:0]  ae_thr,
    output logic              wr_go,
    output logic              rd_go,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              overrun,
    output logic              underrun
);
    fill_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (wr_go) state_d = ST_MID;
            end
            ST_MID: begin
                if (wr_go && !rd_go && cnt_q == CNT_W'(DEPTH - 1))
                    state_d = ST_FULL;
                else if (rd_go && !wr_go && cnt_q == CNT_W'(1))
                    state_d = ST_EMPTY;
            end
            ST_FULL: begin
                if (rd_go) state_d = ST_MID;
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs decoded from the state and occupancy
    always_comb begin
        full         = (state_q == ST_FULL);
        empty        = (state_q == ST_EMPTY);
        wr_go        = wr_en && !full;
        rd_go        = rd_en && !empty;
        almost_full  = (cnt_q >= af_thr);
        almost_empty = (cnt_q <= ae_thr);
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case ({wr_go, rd_go})
            2'b10:   cnt_d = cnt_q + CNT_W'(1);
            2'b01:   cnt_d = cnt_q - CNT_W'(1);
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            overrun  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_go) wr_ptr <= wr_ptr + PTR_W'(1);
            if (rd_go) rd_ptr <= rd_ptr + PTR_W'(1);
            if (wr_en && full)      overrun <= 1'b1;
            else if (err_clr)       overrun <= 1'b0;
            if (rd_en && empty)     underrun <= 1'b1;
            else if (err_clr)       underrun <= 1'b0;
        end
    end
endmodule

// File: rtl/bfifo_rdpath.sv
module bfifo_rdpath #(
    parameter int LANES   = 1,
    parameter int LANE_W  = 36,
    parameter int LSEL_W  = 1,
    parameter int PAY_W   = 32,
    parameter int NPAR    = 4,
    parameter bit OUT_REG = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rd_go,
    input  logic [LSEL_W-1:0]        rd_lane,
    input  logic [LANES*LANE_W-1:0]  rword,
    output logic [PAY_W-1:0]         rd_data,
    output logic [NPAR-1:0]          rd_par,
    output logic                     rd_valid
);
    logic [LSEL_W-1:0] lane_q;
    logic              v1_q;
    logic [LANE_W-1:0] lane_word;

    // lane select travels alongside the memory read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q <= '0;
            v1_q   <= 1'b0;
        end else begin
            v1_q <= rd_go;
            if (rd_go) lane_q <= rd_lane;
        end
    end

    always_comb begin
        lane_word = rword[LANE_W-1:0];
        for (int l = 1; l < LANES; l++) begin
            if (lane_q == LSEL_W'(l)) lane_word = rword[l*LANE_W +: LANE_W];
        end
    end

    generate
        if (OUT_REG) begin : g_outreg
            logic [LANE_W-1:0] out_q;
            logic              v2_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    out_q <= '0;
                    v2_q  <= 1'b0;
                end else begin
                    v2_q <= v1_q;
                    if (v1_q) out_q <= lane_word;
                end
            end
            assign rd_data  = out_q[PAY_W-1:0];
            assign rd_par   = out_q[LANE_W-1:PAY_W];
            assign rd_valid = v2_q;
        end else begin : g_direct
            assign rd_data  = lane_word[PAY_W-1:0];
            assign rd_par   = lane_word[LANE_W-1:PAY_W];
            assign rd_valid = v1_q;
        end
    endgenerate
endmodule

// File: rtl/bram_fifo.sv
module bram_fifo
    import bfifo_pkg::*;
#(
    parameter int DW      = 36,
    parameter bit OUT_REG = 1'b0,
    localparam int PAY_W  = DW / 9 * 8,
    localparam int NPAR   = DW / 9,
    localparam int LANES  = MEM_BITS / DW,
    localparam int DEPTH  = MEM_WORDS * LANES,
    localparam int PTR_W  = $clog2(DEPTH),
    localparam int CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PAY_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic              err_clr,
    input  logic [CNT_W-1:0]  af_thr,
    input  logic [CNT_W-1:0]  ae_thr,
    output logic [PAY_W-1:0]  rd_data,
    output logic [NPAR-1:0]   rd_par,
    output logic              rd_valid,
    output logic              full,
    output logic              empty,
    output logic              almost_full,
    output logic              almost_empty,
    output logic              overrun,
    output logic              underrun
);
    localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic                    wr_go, rd_go;
    logic [PTR_W-1:0]        wr_ptr, rd_ptr;
    logic [MEM_ADDR_W-1:0]   waddr, raddr;
    logic [LSEL_W-1:0]       wr_lane, rd_lane;
    logic [LANES-1:0]        wlane;
    logic [NPAR-1:0]         wpar;
    logic [LANES*DW-1:0]     rword;

    bfifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .err_clr(err_clr), .af_thr(af_thr), .ae_thr(ae_thr),
        .wr_go(wr_go), .rd_go(rd_go), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .full(full), .empty(empty), .almost_full(almost_full),
        .almost_empty(almost_empty), .overrun(overrun), .underrun(underrun)
    );

    // split pointers into memory word address and lane within the word
    generate
        if (LANES > 1) begin : g_lanes
            assign waddr   = wr_ptr[PTR_W-1:LSEL_W];
            assign raddr   = rd_ptr[PTR_W-1:LSEL_W];
            assign wr_lane = wr_ptr[LSEL_W-1:0];
            assign rd_lane = rd_ptr[LSEL_W-1:0];
        end else begin : g_single
            assign waddr   = wr_ptr;
            assign raddr   = rd_ptr;
            assign wr_lane = '0;
            assign rd_lane = '0;
        end

        for (genvar l = 0; l < LANES; l++) begin : g_wlane
            assign wlane[l] = (wr_lane == LSEL_W'(l));
        end

        for (genvar p = 0; p < NPAR; p++) begin : g_par
            assign wpar[p] = ^wr_data[p*8 +: 8];
        end
    endgenerate

    bfifo_mem #(.LANES(LANES), .LANE_W(DW), .WORDS(MEM_WORDS), .ADDR_W(MEM_ADDR_W)) u_mem (
        .clk(clk), .we(wr_go), .waddr(waddr), .wlane(wlane),
        .wdata({wpar, wr_data}), .re(rd_go), .raddr(raddr), .rword(rword)
    );

    bfifo_rdpath #(.LANES(LANES), .LANE_W(DW), .LSEL_W(LSEL_W), .PAY_W(PAY_W),
                   .NPAR(NPAR), .OUT_REG(OUT_REG)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_go(rd_go), .rd_lane(rd_lane),
        .rword(rword), .rd_data(rd_data), .rd_par(rd_par), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/bfifo_chk.sv
module bfifo_chk #(
    parameter bit OUT_REG = 1'b0
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic err_clr,
    input logic full,
    input logic empty,
    input logic overrun,
    input logic underrun,
    input logic rd_valid
);
    a_r3_not_full_and_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && full) |=> overrun);

    a_r5_overrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !err_clr) |=> overrun);

    a_r6_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> underrun);

    a_r6_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !err_clr) |=> underrun);

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !(wr_en && full) && !(rd_en && empty)) |=> (!overrun && !underrun));

    a_r7_rw_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && !full && !empty) |=> (!full && !empty));

    generate
        if (OUT_REG) begin : g_lat2
            a_r4_latency_two: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !empty) |=> ##1 rd_valid);
        end else begin : g_lat1
            a_r4_latency_one: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !empty) |=> rd_valid);
            a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
                rd_valid |-> $past(rd_en && !empty));
        end
    endgenerate
endmodule

bind bram_fifo bfifo_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .err_clr(err_clr),
    .full(full), .empty(empty), .overrun(overrun), .underrun(underrun),
    .rd_valid(rd_valid)
);

// File: tb/bram_fifo_tb.sv
`timescale 1ns/1ps
module bram_fifo_tb;
    localparam int DN = 4096;
    localparam int DWD = 1024;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, err_clr = 1'b0;
    logic [7:0]  wd_n = '0;
    logic [31:0] wd_w = '0;
    logic [12:0] af_n = 13'd8, ae_n = 13'd3;
    logic [10:0] af_w = 11'd8, ae_w = 11'd3;

    logic [7:0]  rd_n;  logic [0:0] par_n;
    logic [31:0] rd_w;  logic [3:0] par_w;
    logic v_n, full_n, empty_n, afl_n, ael_n, ovr_n, und_n;
    logic v_w, full_w, empty_w, afl_w, ael_w, ovr_w, und_w;

    int checks = 0, fails = 0, seq = 0, cnt_n = 0, cnt_w = 0;
    bit done = 1'b0;
    logic [7:0]  q_n[$];
    logic [31:0] q_w[$];

    always #4 clk = ~clk;

    // narrow mode with output register
    bram_fifo #(.DW(9), .OUT_REG(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wd_n), .rd_en(rd_en),
        .err_clr(err_clr), .af_thr(af_n), .ae_thr(ae_n), .rd_data(rd_n),
        .rd_par(par_n), .rd_valid(v_n), .full(full_n), .empty(empty_n),
        .almost_full(afl_n), .almost_empty(ael_n), .overrun(ovr_n), .underrun(und_n));

    // wide mode without output register
    bram_fifo #(.DW(36), .OUT_REG(1'b0)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wd_w), .rd_en(rd_en),
        .err_clr(err_clr), .af_thr(af_w), .ae_thr(ae_w), .rd_data(rd_w),
        .rd_par(par_w), .rd_valid(v_w), .full(full_w), .empty(empty_w),
        .almost_full(afl_w), .almost_empty(ael_w), .overrun(ovr_w), .underrun(und_w));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chkb(input string req, input logic act, input logic exp);
        chk(act === exp, req, act, exp);
    endtask

    function automatic logic [31:0] wide_of(input logic [7:0] b);
        return {b ^ 8'hA5, b + 8'd7, ~b, b};
    endfunction

    // driver: sets inputs, updates the reference queues, waits one edge
    task automatic cyc(input logic we, input logic re, input logic clr);
        bit wn, rn, ww, rw;
        wr_en = we; rd_en = re; err_clr = clr;
        wd_n = seq[7:0];
        wd_w = wide_of(seq[7:0]);
        wn = we && (cnt_n < DN);  rn = re && (cnt_n > 0);
        ww = we && (cnt_w < DWD); rw = re && (cnt_w > 0);
        if (wn) q_n.push_back(wd_n);
        if (ww) q_w.push_back(wd_w);
        cnt_n = cnt_n + int'(wn) - int'(rn);
        cnt_w = cnt_w + int'(ww) - int'(rw);
        if (we) seq++;
        @(posedge clk); #1;
    endtask

    // monitor: compares every delivered word against the queue head (R2, R9)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (v_n) begin
                if (q_n.size() == 0) chk(1'b0, "R2 narrow unexpected rd_valid", 1, 0);
                else begin
                    logic [7:0] e;
                    e = q_n.pop_front();
                    chk(rd_n === e, "R2 narrow data order", rd_n, e);
                    chk(par_n[0] === ^e, "R9 narrow parity", par_n, ^e);
                end
            end
            if (v_w) begin
                if (q_w.size() == 0) chk(1'b0, "R2 wide unexpected rd_valid", 1, 0);
                else begin
                    logic [31:0] e;
                    logic [3:0]  p;
                    e = q_w.pop_front();
                    for (int i = 0; i < 4; i++) p[i] = ^e[i*8 +: 8];
                    chk(rd_w === e, "R2 wide data order", rd_w, e);
                    chk(par_w === p, "R9 wide parity", par_w, p);
                end
            end
        end
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R3 reset state
        chkb("R3 reset empty n", empty_n, 1'b1); chkb("R3 reset empty w", empty_w, 1'b1);
        chkb("R3 reset full n", full_n, 1'b0);   chkb("R3 reset full w", full_w, 1'b0);
        chkb("R3 reset overrun", ovr_n | ovr_w, 1'b0);
        chkb("R3 reset underrun", und_n | und_w, 1'b0);
        chkb("R3 reset rd_valid", v_n | v_w, 1'b0);
        chkb("R8 reset almost_empty", ael_n & ael_w, 1'b1);

        // R6 read while empty
        cyc(0, 1, 0);
        chkb("R6 underrun n", und_n, 1'b1); chkb("R6 underrun w", und_w, 1'b1);
        chkb("R6 still empty", empty_n & empty_w, 1'b1);
        cyc(0, 0, 0); cyc(0, 0, 0);
        chkb("R6 no rd_valid", v_n | v_w, 1'b0);
        chkb("R6 underrun sticky", und_n & und_w, 1'b1);
        // R10 clear
        cyc(0, 0, 1);
        chkb("R10 underrun cleared", und_n | und_w, 1'b0);
        cyc(0, 0, 0);

        // R8 almost flags around thresholds (ae=3, af=8)
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        chkb("R8 almost_empty at 3 n", ael_n, 1'b1); chkb("R8 almost_empty at 3 w", ael_w, 1'b1);
        chkb("R3 not empty", empty_n | empty_w, 1'b0);
        cyc(1, 0, 0);
        chkb("R8 almost_empty at 4 n", ael_n, 1'b0); chkb("R8 almost_empty at 4 w", ael_w, 1'b0);
        for (int i = 0; i < 3; i++) cyc(1, 0, 0);
        chkb("R8 almost_full at 7 n", afl_n, 1'b0); chkb("R8 almost_full at 7 w", afl_w, 1'b0);
        cyc(1, 0, 0);
        chkb("R8 almost_full at 8 n", afl_n, 1'b1); chkb("R8 almost_full at 8 w", afl_w, 1'b1);

        // R7 simultaneous read and write keeps occupancy at 8
        for (int i = 0; i < 4; i++) cyc(1, 1, 0);
        chkb("R7 almost_full held n", afl_n, 1'b1); chkb("R7 almost_full held w", afl_w, 1'b1);
        cyc(0, 1, 0);
        chkb("R7 lone read drops to 7 n", afl_n, 1'b0); chkb("R7 lone read drops to 7 w", afl_w, 1'b0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0);

        // R4 latency: wide one cycle, narrow (output register) two cycles
        cyc(0, 1, 0);
        chkb("R4 wide valid at +1", v_w, 1'b1);
        chkb("R4 narrow not valid at +1", v_n, 1'b0);
        cyc(0, 0, 0);
        chkb("R4 narrow valid at +2", v_n, 1'b1);
        chkb("R4 wide single valid", v_w, 1'b0);

        // drain
        while (cnt_n > 0) cyc(0, 1, 0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 0);
        chkb("R3 empty after drain n", empty_n, 1'b1); chkb("R3 empty after drain w", empty_w, 1'b1);

        // R1 depth per mode
        for (int i = 0; i < DWD; i++) cyc(1, 0, 0);
        chkb("R1 wide full at 1024", full_w, 1'b1);
        chkb("R1 narrow not full at 1024", full_n, 1'b0);
        cyc(1, 0, 0);
        chkb("R5 wide overrun", ovr_w, 1'b1);
        chkb("R5 narrow no overrun", ovr_n, 1'b0);
        for (int i = 0; i < DN - DWD - 2; i++) cyc(1, 0, 0);
        chkb("R1 narrow not full at 4095", full_n, 1'b0);
        cyc(1, 0, 0);
        chkb("R1 narrow full at 4096", full_n, 1'b1);
        chkb("R5 wide overrun sticky", ovr_w, 1'b1);

        // R7/R5 read and write together at full: read taken, write dropped
        cyc(1, 1, 0);
        chkb("R5 narrow overrun on rw at full", ovr_n, 1'b1);
        chkb("R7 narrow leaves full", full_n, 1'b0);
        chkb("R7 wide leaves full", full_w, 1'b0);
        cyc(1, 0, 0);
        chkb("R1 narrow full again", full_n, 1'b1);
        // R5 set wins over clear
        cyc(1, 0, 1);
        chkb("R5 set beats clear n", ovr_n, 1'b1); chkb("R5 set beats clear w", ovr_w, 1'b1);
        cyc(0, 0, 1);
        chkb("R10 overrun cleared", ovr_n | ovr_w, 1'b0);
        cyc(0, 0, 0);

        // drain everything; the monitor checks order and parity
        while (cnt_n > 0) cyc(0, 1, 0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0);
        chkb("R3 empty at end", empty_n & empty_w, 1'b1);
        chk(q_n.size() == 0, "R2 narrow all delivered", q_n.size(), 0);
        chk(q_w.size() == 0, "R2 wide all delivered", q_w.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule